// File: doc/BRIEF.md
# Integer Execution Unit with Signed-Overflow Trap

This block is the combinational integer datapath of a small load-store RISC core. In every cycle it takes two register operands (`src_a` is the first source, `src_b` the second), a 16-bit immediate, a shift count and a 5-bit operation code. From these it produces a result word, a signed-overflow trap flag and a write-enable that tells the register file whether to commit the result.

One adder serves both addition and subtraction. Signed and unsigned forms differ only in whether overflow raises the trap. Immediate arithmetic widens the immediate with sign extension, and immediate logic widens it with zeros. Shifts take their count either from the dedicated count input or from the low bits of `src_a`. When a trap is raised, the write-enable drops so that the destination register keeps its old value. Decoding of raw instruction words, multiply and divide, and handling of the trap itself all live outside this block.

Top module: `int_alu_trap`

## Requirements
- R1: ADD (code 0) and ADDU (code 1) output `src_a + src_b` modulo 2^32. SUB (code 2) and SUBU (code 3) output `src_a - src_b` modulo 2^32.
- R2: ADD, SUB and ADDI (code 16) raise `ovf_trap` exactly on signed overflow. For an add this means the two operands share a sign and the result sign differs. For a subtract it means the operand signs differ and the result sign differs from `src_a`. The wrapped result is still driven on `result`.
- R3: ADDU, SUBU and ADDIU (code 17) never raise `ovf_trap`, whatever the operand values.
- R4: ADDI and ADDIU replace `src_b` with `imm16` sign-extended to 32 bits. `src_b` has no effect on them.
- R5: ANDI (code 20), ORI (code 21) and XORI (code 22) combine `src_a` with `imm16` zero-extended to 32 bits, using AND, OR and XOR respectively.
- R6: AND (code 4), OR (code 5), NOR (code 6) and XOR (code 7) apply their bitwise function to `src_a` and `src_b`.
- R7: SLL (code 8) shifts `src_b` left by `shamt` and fills with zeros. SRL (code 9) shifts right and fills with zeros. SRA (code 10) shifts right and fills with copies of bit 31. A count of 0 passes `src_b` through unchanged.
- R8: SLLV (code 11), SRLV (code 12) and SRAV (code 13) behave like codes 8 to 10, but take the count from `src_a[4:0]`. The upper bits of `src_a` and the `shamt` input have no effect on them.
- R9: For every defined code, `wr_en` is the inverse of `ovf_trap`. Any undefined code drives `result` to 0, `ovf_trap` to 0 and `wr_en` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 5 | Operation code (values listed in the requirements) |
| src_a | input | 32 | First source operand; also supplies the count for variable shifts |
| src_b | input | 32 | Second source operand; the value shifted by all shift codes |
| imm16 | input | 16 | Immediate field |
| shamt | input | 5 | Constant shift count |
| result | output | 32 | Operation result |
| ovf_trap | output | 1 | Signed-overflow trap for the trapping arithmetic codes |
| wr_en | output | 1 | Destination write-enable |

## Verification
Two functions can act in the same cycle: overflow detection and result generation. The overflow path must raise the trap and drop the write-enable, and the adder must still deliver its wrapped sum on `result`. The bench drives operand pairs that cross the signed boundary in each direction, for example 0x7FFFFFFF plus 1, 0x80000000 minus 1 and 0 minus 0x80000000. For each pair it judges three outputs together in one sample: the expected wrapped value, a high trap and a low write-enable. The same pairs are then applied with the unsigned codes, where the trap must stay low and the write must be allowed.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

   typedef enum logic [4:0] {
      OP_ADD   = 5'd0,
      OP_ADDU  = 5'd1,
      OP_SUB   = 5'd2,
      OP_SUBU  = 5'd3,
      OP_AND   = 5'd4,
      OP_OR    = 5'd5,
      OP_NOR   = 5'd6,
      OP_XOR   = 5'd7,
      OP_SLL   = 5'd8,
      OP_SRL   = 5'd9,
      OP_SRA   = 5'd10,
      OP_SLLV  = 5'd11,
      OP_SRLV  = 5'd12,
      OP_SRAV  = 5'd13,
      OP_ADDI  = 5'd16,
      OP_ADDIU = 5'd17,
      OP_ANDI  = 5'd20,
      OP_ORI   = 5'd21,
      OP_XORI  = 5'd22
   } alu_op_e;

   typedef enum logic [1:0] {
      UNIT_NONE,
      UNIT_ARITH,
      UNIT_LOGIC,
      UNIT_SHIFT
   } unit_e;

   typedef enum logic [1:0] {
      BSEL_REG,
      BSEL_SEXT,
      BSEL_ZEXT
   } bsel_e;

   typedef enum logic [1:0] {
      LFN_AND,
      LFN_OR,
      LFN_NOR,
      LFN_XOR
   } lfn_e;

   typedef enum logic [1:0] {
      SHK_LEFT,
      SHK_RIGHT_LOG,
      SHK_RIGHT_ARI
   } shk_e;

   typedef struct packed {
      unit_e unit;
      bsel_e bsel;
      logic  do_sub;
      logic  trap_en;
      lfn_e  lfn;
      shk_e  shk;
      logic  shift_var;
      logic  legal;
   } alu_ctrl_t;

endpackage

// File: rtl/int_alu_decode.sv
module int_alu_decode
   import int_alu_pkg::*;
(
   input  logic [4:0] op_sel,
   output alu_ctrl_t  ctrl
);

   always_comb begin
      ctrl = '{unit: UNIT_NONE, bsel: BSEL_REG, do_sub: 1'b0, trap_en: 1'b0,
               lfn: LFN_AND, shk: SHK_LEFT, shift_var: 1'b0, legal: 1'b1};
      case (alu_op_e'(op_sel))
         OP_ADD:   begin ctrl.unit = UNIT_ARITH; ctrl.trap_en = 1'b1; end
         OP_ADDU:  ctrl.unit = UNIT_ARITH;
         OP_SUB:   begin ctrl.unit = UNIT_ARITH; ctrl.do_sub = 1'b1; ctrl.trap_en = 1'b1; end
         OP_SUBU:  begin ctrl.unit = UNIT_ARITH; ctrl.do_sub = 1'b1; end
         OP_AND:   begin ctrl.unit = UNIT_LOGIC; ctrl.lfn = LFN_AND; end
         OP_OR:    begin ctrl.unit = UNIT_LOGIC; ctrl.lfn = LFN_OR;  end
         OP_NOR:   begin ctrl.unit = UNIT_LOGIC; ctrl.lfn = LFN_NOR; end
         OP_XOR:   begin ctrl.unit = UNIT_LOGIC; ctrl.lfn = LFN_XOR; end
         OP_SLL:   begin ctrl.unit = UNIT_SHIFT; ctrl.shk = SHK_LEFT; end
         OP_SRL:   begin ctrl.unit = UNIT_SHIFT; ctrl.shk = SHK_RIGHT_LOG; end
         OP_SRA:   begin ctrl.unit = UNIT_SHIFT; ctrl.shk = SHK_RIGHT_ARI; end
         OP_SLLV:  begin ctrl.unit = UNIT_SHIFT; ctrl.shk = SHK_LEFT;      ctrl.shift_var = 1'b1; end
         OP_SRLV:  begin ctrl.unit = UNIT_SHIFT; ctrl.shk = SHK_RIGHT_LOG; ctrl.shift_var = 1'b1; end
         OP_SRAV:  begin ctrl.unit = UNIT_SHIFT; ctrl.shk = SHK_RIGHT_ARI; ctrl.shift_var = 1'b1; end
         OP_ADDI:  begin ctrl.unit = UNIT_ARITH; ctrl.bsel = BSEL_SEXT; ctrl.trap_en = 1'b1; end
         OP_ADDIU: begin ctrl.unit = UNIT_ARITH; ctrl.bsel = BSEL_SEXT; end
         OP_ANDI:  begin ctrl.unit = UNIT_LOGIC; ctrl.bsel = BSEL_ZEXT; ctrl.lfn = LFN_AND; end
         OP_ORI:   begin ctrl.unit = UNIT_LOGIC; ctrl.bsel = BSEL_ZEXT; ctrl.lfn = LFN_OR;  end
         OP_XORI:  begin ctrl.unit = UNIT_LOGIC; ctrl.bsel = BSEL_ZEXT; ctrl.lfn = LFN_XOR; end
         default:  ctrl.legal = 1'b0;
      endcase
   end

   // R2/R3: only arithmetic codes may ever enable the trap
   always_comb begin
      if (!$isunknown(op_sel))
         a_r3_trap_only_arith: assert (!ctrl.trap_en || ctrl.unit == UNIT_ARITH)
            else $error("trap enabled on non-arithmetic code");
   end

endmodule

// File: rtl/int_alu_addsub.sv
module int_alu_addsub #(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   input  logic              do_sub,
   input  logic              trap_en,
   output logic [DATA_W-1:0] sum,
   output logic              trap
);

   localparam int MSB = DATA_W - 1;

   logic [DATA_W-1:0] opb_eff;
   logic              ovf;

   always_comb begin
      opb_eff = do_sub ? ~opb : opb;
      sum     = opa + opb_eff + {{(DATA_W-1){1'b0}}, do_sub};
      ovf     = (opa[MSB] == opb_eff[MSB]) && (sum[MSB] != opa[MSB]);
      trap    = trap_en && ovf;
   end

   // R1: a difference added back to the subtrahend returns the minuend
   always_comb begin
      if (!$isunknown({opa, opb, do_sub}) && do_sub)
         a_r1_sub_inverse: assert (sum + opb == opa)
            else $error("subtract result inconsistent");
   end

   // R2: an add of opposite-sign operands can never overflow
   always_comb begin
      if (!$isunknown({opa, opb, do_sub, trap_en}) && !do_sub && (opa[MSB] != opb[MSB]))
         a_r2_mixed_sign_add_safe: assert (!trap)
            else $error("trap on mixed-sign add");
   end

endmodule

// File: rtl/int_alu_logic.sv
module int_alu_logic
   import int_alu_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   input  lfn_e              lfn,
   output logic [DATA_W-1:0] dout
);

   always_comb begin
      case (lfn)
         LFN_AND: dout = opa & opb;
         LFN_OR:  dout = opa | opb;
         LFN_NOR: dout = ~(opa | opb);
         default: dout = opa ^ opb;
      endcase
   end

   // R6: NOR and OR are exact complements on the same operands
   always_comb begin
      if (!$isunknown({opa, opb, lfn}) && lfn == LFN_NOR)
         a_r6_nor_disjoint: assert ((dout & (opa | opb)) == '0)
            else $error("NOR overlaps operand ones");
   end

endmodule

// File: rtl/int_alu_shift.sv
module int_alu_shift
   import int_alu_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int SHAMT_W  = $clog2(DATA_W),
   parameter bit USE_BARREL = 1'b1
) (
   input  logic [DATA_W-1:0]  din,
   input  logic [SHAMT_W-1:0] amt,
   input  shk_e               shk,
   output logic [DATA_W-1:0]  dout
);

   localparam int MSB = DATA_W - 1;

   function automatic logic [DATA_W-1:0] bit_rev(input logic [DATA_W-1:0] v);
      logic [DATA_W-1:0] r;
      for (int i = 0; i < DATA_W; i++) r[i] = v[MSB-i];
      return r;
   endfunction

   logic is_left;
   logic fill;

   always_comb begin
      is_left = (shk == SHK_LEFT);
      fill    = (shk == SHK_RIGHT_ARI) ? din[MSB] : 1'b0;
   end

   generate
      if (USE_BARREL) begin : g_barrel
         logic [DATA_W-1:0] stage [0:SHAMT_W];
         logic [DATA_W-1:0] rev_out;
         assign stage[0] = is_left ? bit_rev(din) : din;
         for (genvar g = 0; g < SHAMT_W; g++) begin : g_stage
            localparam int STEP = 1 << g;
            assign stage[g+1] = amt[g] ? {{STEP{fill}}, stage[g][MSB:STEP]} : stage[g];
         end
         assign rev_out = bit_rev(stage[SHAMT_W]);
         assign dout    = is_left ? rev_out : stage[SHAMT_W];
      end else begin : g_operator
         always_comb begin
            case (shk)
               SHK_LEFT:      dout = din << amt;
               SHK_RIGHT_ARI: dout = $signed(din) >>> amt;
               default:       dout = din >> amt;
            endcase
         end
      end
   endgenerate

   // R7: arithmetic right shift preserves the sign bit
   always_comb begin
      if (!$isunknown({din, amt, shk}) && shk == SHK_RIGHT_ARI)
         a_r7_sra_keeps_sign: assert (dout[MSB] == din[MSB])
            else $error("arithmetic shift lost sign");
   end

   // R7: any nonzero left shift clears bit 0, nonzero logical right clears the MSB
   always_comb begin
      if (!$isunknown({din, amt, shk}) && amt != '0) begin
         if (shk == SHK_LEFT)
            a_r7_sll_zero_fill: assert (dout[0] == 1'b0) else $error("left shift fill");
         if (shk == SHK_RIGHT_LOG)
            a_r7_srl_zero_fill: assert (dout[MSB] == 1'b0) else $error("right shift fill");
      end
   end

endmodule

// File: rtl/int_alu_trap.sv
module int_alu_trap
   import int_alu_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int IMM_W      = 16,
   parameter bit USE_BARREL = 1'b1,
   localparam int SHAMT_W   = $clog2(DATA_W)
) (
   input  logic [4:0]         op_sel,
   input  logic [DATA_W-1:0]  src_a,
   input  logic [DATA_W-1:0]  src_b,
   input  logic [IMM_W-1:0]   imm16,
   input  logic [SHAMT_W-1:0] shamt,
   output logic [DATA_W-1:0]  result,
   output logic               ovf_trap,
   output logic               wr_en
);

   generate
      if (DATA_W != (1 << SHAMT_W)) begin : g_chk_pow2
         $error("DATA_W must be a power of two");
      end
      if (IMM_W >= DATA_W || IMM_W < 1) begin : g_chk_imm
         $error("IMM_W must be between 1 and DATA_W-1");
      end
   endgenerate

   alu_ctrl_t          ctrl;
   logic [DATA_W-1:0]  opb;
   logic [DATA_W-1:0]  arith_q;
   logic [DATA_W-1:0]  logic_q;
   logic [DATA_W-1:0]  shift_q;
   logic [SHAMT_W-1:0] shift_amt;
   logic               arith_trap;

   int_alu_decode u_dec (
      .op_sel (op_sel),
      .ctrl   (ctrl)
   );

   always_comb begin
      case (ctrl.bsel)
         BSEL_SEXT: opb = {{(DATA_W-IMM_W){imm16[IMM_W-1]}}, imm16};
         BSEL_ZEXT: opb = {{(DATA_W-IMM_W){1'b0}}, imm16};
         default:   opb = src_b;
      endcase
      shift_amt = ctrl.shift_var ? src_a[SHAMT_W-1:0] : shamt;
   end

   int_alu_addsub #(.DATA_W(DATA_W)) u_arith (
      .opa     (src_a),
      .opb     (opb),
      .do_sub  (ctrl.do_sub),
      .trap_en (ctrl.trap_en),
      .sum     (arith_q),
      .trap    (arith_trap)
   );

   int_alu_logic #(.DATA_W(DATA_W)) u_logic (
      .opa  (src_a),
      .opb  (opb),
      .lfn  (ctrl.lfn),
      .dout (logic_q)
   );

   int_alu_shift #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W), .USE_BARREL(USE_BARREL)) u_shift (
      .din  (src_b),
      .amt  (shift_amt),
      .shk  (ctrl.shk),
      .dout (shift_q)
   );

   always_comb begin
      case (ctrl.unit)
         UNIT_ARITH: result = arith_q;
         UNIT_LOGIC: result = logic_q;
         UNIT_SHIFT: result = shift_q;
         default:    result = '0;
      endcase
      ovf_trap = (ctrl.unit == UNIT_ARITH) && arith_trap;
      wr_en    = ctrl.legal && !ovf_trap;
   end

   // R9: a raised trap always suppresses the write
   always_comb begin
      if (!$isunknown({op_sel, src_a, src_b, imm16}))
         a_r9_trap_blocks_write: assert (!(ovf_trap && wr_en))
            else $error("write enabled during trap");
   end

   // R3: unsigned arithmetic codes never trap
   always_comb begin
      if (!$isunknown(op_sel) &&
          (op_sel == 5'd1 || op_sel == 5'd3 || op_sel == 5'd17))
         a_r3_unsigned_no_trap: assert (!ovf_trap)
            else $error("unsigned code trapped");
   end

   // R2: a trap is only seen on the signed trapping codes
   always_comb begin
      if (!$isunknown(op_sel) && ovf_trap)
         a_r2_trap_signed_only: assert (op_sel == 5'd0 || op_sel == 5'd2 || op_sel == 5'd16)
            else $error("trap on non-trapping code");
   end

endmodule

// File: tb/int_alu_trap_tb.sv
module int_alu_trap_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 5000;

   logic        clk = 1'b0;
   logic [4:0]  op_sel;
   logic [31:0] src_a, src_b;
   logic [15:0] imm16;
   logic [4:0]  shamt;
   logic [31:0] result;
   logic        ovf_trap, wr_en;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   int_alu_trap dut_i (
      .op_sel   (op_sel),
      .src_a    (src_a),
      .src_b    (src_b),
      .imm16    (imm16),
      .shamt    (shamt),
      .result   (result),
      .ovf_trap (ovf_trap),
      .wr_en    (wr_en)
   );

   task automatic drive(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b,
                        input logic [15:0] imm, input logic [4:0] sh);
      @(negedge clk);
      op_sel = op; src_a = a; src_b = b; imm16 = imm; shamt = sh;
      #(CLK_PERIOD/4);
   endtask

   task automatic check(input string req, input logic [31:0] exp_res,
                        input logic exp_trap, input logic exp_we);
      n_checks++;
      if (result !== exp_res || ovf_trap !== exp_trap || wr_en !== exp_we) begin
         n_fails++;
         $display("FAIL %s op=%0d: result=%h trap=%b we=%b expected result=%h trap=%b we=%b",
                  req, op_sel, result, ovf_trap, wr_en, exp_res, exp_trap, exp_we);
      end
   endtask

   task automatic t_idle;
      drive(5'd0, 32'h0, 32'h0, 16'h0, 5'd0);
      check("R1 idle zero", 32'h0, 1'b0, 1'b1);
   endtask

   task automatic t_arith;
      drive(5'd0, 32'd5, 32'd7, 16'hFFFF, 5'd3);           check("R1 add", 32'd12, 1'b0, 1'b1);
      drive(5'd1, 32'hFFFF_FFFF, 32'd1, 16'h0, 5'd0);      check("R1 addu wrap", 32'h0, 1'b0, 1'b1);
      drive(5'd2, 32'd3, 32'd5, 16'h0, 5'd0);              check("R1 sub order", 32'hFFFF_FFFE, 1'b0, 1'b1);
      drive(5'd3, 32'd0, 32'd1, 16'h0, 5'd0);              check("R1 subu", 32'hFFFF_FFFF, 1'b0, 1'b1);
      drive(5'd0, 32'hFFFF_FFFF, 32'd1, 16'h0, 5'd0);      check("R2 add -1+1 no ovf", 32'h0, 1'b0, 1'b1);
   endtask

   task automatic t_overflow;
      drive(5'd0, 32'h7FFF_FFFF, 32'd1, 16'h0, 5'd0);      check("R2 add pos ovf", 32'h8000_0000, 1'b1, 1'b0);
      drive(5'd0, 32'h8000_0000, 32'h8000_0000, 16'h0, 5'd0); check("R2 add neg ovf", 32'h0, 1'b1, 1'b0);
      drive(5'd2, 32'h8000_0000, 32'd1, 16'h0, 5'd0);      check("R2 sub neg ovf", 32'h7FFF_FFFF, 1'b1, 1'b0);
      drive(5'd2, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 16'h0, 5'd0); check("R2 sub pos ovf", 32'h8000_0000, 1'b1, 1'b0);
      drive(5'd2, 32'h0, 32'h8000_0000, 16'h0, 5'd0);      check("R2 0-min ovf", 32'h8000_0000, 1'b1, 1'b0);
      drive(5'd2, 32'hFFFF_FFFF, 32'h8000_0000, 16'h0, 5'd0); check("R2 -1-min ok", 32'h7FFF_FFFF, 1'b0, 1'b1);
   endtask

   task automatic t_unsigned;
      drive(5'd1, 32'h7FFF_FFFF, 32'd1, 16'h0, 5'd0);      check("R3 addu no trap", 32'h8000_0000, 1'b0, 1'b1);
      drive(5'd3, 32'h8000_0000, 32'd1, 16'h0, 5'd0);      check("R3 subu no trap", 32'h7FFF_FFFF, 1'b0, 1'b1);
      drive(5'd17, 32'h8000_0000, 32'h0, 16'hFFFF, 5'd0);  check("R3 addiu no trap", 32'h7FFF_FFFF, 1'b0, 1'b1);
   endtask

   task automatic t_imm_arith;
      drive(5'd16, 32'd10, 32'h1234_5678, 16'hFFFF, 5'd0); check("R4 addi neg imm", 32'd9, 1'b0, 1'b1);
      drive(5'd17, 32'd0, 32'hDEAD_BEEF, 16'h8000, 5'd0);  check("R4 addiu sext", 32'hFFFF_8000, 1'b0, 1'b1);
      drive(5'd16, 32'h8000_0000, 32'd0, 16'hFFFF, 5'd0);  check("R4 R2 addi ovf", 32'h7FFF_FFFF, 1'b1, 1'b0);
   endtask

   task automatic t_imm_logic;
      drive(5'd20, 32'hFFFF_FFFF, 32'h0, 16'h8001, 5'd0);  check("R5 andi zext", 32'h0000_8001, 1'b0, 1'b1);
      drive(5'd21, 32'h1234_0000, 32'hFFFF_FFFF, 16'hF00F, 5'd0); check("R5 ori", 32'h1234_F00F, 1'b0, 1'b1);
      drive(5'd22, 32'hFFFF_0000, 32'h0, 16'hFFFF, 5'd0);  check("R5 xori", 32'hFFFF_FFFF, 1'b0, 1'b1);
   endtask

   task automatic t_reg_logic;
      logic [31:0] a = 32'hF0F0_1234;
      logic [31:0] b = 32'h0FF0_FF00;
      drive(5'd4, a, b, 16'hFFFF, 5'd0); check("R6 and", a & b, 1'b0, 1'b1);
      drive(5'd5, a, b, 16'hFFFF, 5'd0); check("R6 or", a | b, 1'b0, 1'b1);
      drive(5'd6, a, b, 16'hFFFF, 5'd0); check("R6 nor", ~(a | b), 1'b0, 1'b1);
      drive(5'd7, a, b, 16'hFFFF, 5'd0); check("R6 xor", a ^ b, 1'b0, 1'b1);
   endtask

   task automatic t_shift_const;
      drive(5'd8,  32'hFFFF_FFFF, 32'h8000_0001, 16'h0, 5'd1);  check("R7 sll", 32'h0000_0002, 1'b0, 1'b1);
      drive(5'd9,  32'h0, 32'h8000_0000, 16'h0, 5'd31);          check("R7 srl 31", 32'h1, 1'b0, 1'b1);
      drive(5'd10, 32'h0, 32'h8000_0000, 16'h0, 5'd4);           check("R7 sra neg", 32'hF800_0000, 1'b0, 1'b1);
      drive(5'd10, 32'h0, 32'h4000_0000, 16'h0, 5'd30);          check("R7 sra pos", 32'h1, 1'b0, 1'b1);
      drive(5'd9,  32'h0, 32'hDEAD_BEEF, 16'h0, 5'd0);           check("R7 zero count", 32'hDEAD_BEEF, 1'b0, 1'b1);
      drive(5'd8,  32'h0, 32'h0000_0001, 16'h0, 5'd31);          check("R7 sll 31", 32'h8000_0000, 1'b0, 1'b1);
   endtask

   task automatic t_shift_var;
      drive(5'd11, 32'h0000_0023, 32'h1, 16'h0, 5'd31);          check("R8 sllv low bits", 32'h8, 1'b0, 1'b1);
      drive(5'd13, 32'hFFFF_FFE4, 32'h8000_0000, 16'h0, 5'd0);   check("R8 srav", 32'hF800_0000, 1'b0, 1'b1);
      drive(5'd12, 32'h0000_0020, 32'hDEAD_BEEF, 16'h0, 5'd7);   check("R8 srlv count 0", 32'hDEAD_BEEF, 1'b0, 1'b1);
      drive(5'd12, 32'h0000_001F, 32'h8000_0000, 16'h0, 5'd0);   check("R8 srlv 31", 32'h1, 1'b0, 1'b1);
   endtask

   task automatic t_illegal;
      drive(5'd14, 32'h7FFF_FFFF, 32'd1, 16'hFFFF, 5'd3); check("R9 code 14", 32'h0, 1'b0, 1'b0);
      drive(5'd15, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'h0, 5'd0); check("R9 code 15", 32'h0, 1'b0, 1'b0);
      drive(5'd31, 32'h8000_0000, 32'h8000_0000, 16'hFFFF, 5'd1); check("R9 code 31", 32'h0, 1'b0, 1'b0);
      drive(5'd18, 32'h1, 32'h1, 16'h1, 5'd1);            check("R9 code 18", 32'h0, 1'b0, 1'b0);
   endtask

   task automatic finish_run;
      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   endtask

   initial begin
      op_sel = 5'd0; src_a = '0; src_b = '0; imm16 = '0; shamt = '0;
      t_idle();
      t_arith();
      t_overflow();
      t_unsigned();
      t_imm_arith();
      t_imm_logic();
      t_reg_logic();
      t_shift_const();
      t_shift_var();
      t_illegal();
      finish_run();
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog expired after %0d cycles, expected completion", WATCHDOG);
      finish_run();
   end

endmodule